// File: doc/BRIEF.md
# Mode-Tagged Predecode Entry-Point Queue

This block sits between instruction fetch and the execute stage of a small segmented processor model. Each opcode it accepts is turned into a 6-bit microcode entry-point code. The current protection-enable bit (`pe_i`) is an input to that mapping, and its value is sampled at the moment the opcode is decoded. The decoded entry, with its opcode, register field, entry-point code and decode-time PE value, is then held in a short in-order queue until the execute stage takes it.

Because the entry point is fixed at decode time, an entry that was decoded in real mode keeps its real-mode entry point after PE is set. This lasts until a flush empties the queue and the following opcodes are decoded again. A flush comes from two places: the `flush_i` input, which control transfers drive, and the execute stage taking an invalid-opcode entry. On the execute side the block also produces the segment-register update for register-source segment loads. For entry points that both modes share, it raises a descriptor-work request that depends on the live PE bit.

Top module: `predecode_ep_queue`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the queue is empty: `ex_valid_o` is 0 and `dec_ready_o` is 1.
- R2: The opcode-to-entry-point mapping (hex) is as follows. Any opcode not listed maps to 00. Register segment load 8E maps to 01, or to 11 when decoded with PE=1. Memory segment load 8F maps to 02. Far jump EA maps to 03. Far call 9A maps to 04. HLT F4 maps to 05, or to 15 with PE=1. Near jump EB maps to 06. With PE=1, ARPL 63 maps to 16 and STR 0F maps to 17.
- R3: ARPL (63) and STR (0F) decoded with PE=0 map to the invalid-opcode code 3F.
- R4: The entry-point code and the PE value captured at decode (`ex_pe_dec_o`) do not change when `pe_i` changes while the entry waits in the queue.
- R5: The queue holds 4 entries in arrival order. `dec_ready_o` is low exactly when it is full, and an opcode offered while it is full is not taken.
- R6: The head entry is shown on the `ex_*` outputs. It is removed at a clock edge where `ex_valid_o` and `ex_ready_i` are both high.
- R7: `flush_i` empties the queue at the next edge, and it wins over an enqueue in the same cycle.
- R8: When the execute stage takes an entry with code 3F, the queue is emptied at that edge, and an opcode offered in the same cycle is dropped.
- R9: Taking a code-01 entry pulses `seg_we_o` and `seg_base_we_o`. In that cycle `seg_idx_o` is the register field, `seg_sel_o` is `ex_gpr_i`, and `seg_base_o` is `ex_gpr_i` shifted left by 4 as a 20-bit value.
- R10: Taking a code-11 entry pulses `seg_we_o` and `desc_req_o` but not `seg_base_we_o`.
- R11: Taking a code 02, 03 or 04 entry raises `desc_req_o` only if the live `pe_i` is 1 in that cycle, and never writes a segment register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_i | input | 1 | Live protection-enable bit |
| dec_valid_i | input | 1 | Fetch offers an opcode |
| dec_opcode_i | input | 8 | Offered opcode byte |
| dec_reg_i | input | 3 | Offered register field |
| dec_ready_o | output | 1 | Queue can take an opcode |
| flush_i | input | 1 | Control-transfer flush |
| ex_ready_i | input | 1 | Execute takes the head entry |
| ex_gpr_i | input | 16 | General-register value for segment loads |
| ex_valid_o | output | 1 | Head entry present |
| ex_ep_o | output | 6 | Head entry-point code |
| ex_opcode_o | output | 8 | Head opcode |
| ex_reg_o | output | 3 | Head register field |
| ex_pe_dec_o | output | 1 | PE value captured at decode |
| seg_we_o | output | 1 | Write visible selector |
| seg_idx_o | output | 3 | Segment register index |
| seg_sel_o | output | 16 | Selector value |
| seg_base_we_o | output | 1 | Write segment base |
| seg_base_o | output | 20 | Base value |
| desc_req_o | output | 1 | Descriptor work request |

## Verification
If a stored entry point or PE tag were corrupted, it would show on `ex_ep_o` or `ex_pe_dec_o` as soon as that entry reaches the head. A wrong pointer or count would show as a misordered head, or as `dec_ready_o` at the wrong level, in the very next cycle. A flush that leaves an entry behind keeps `ex_valid_o` high one cycle after the flush edge. The bench keeps its own queue model and compares every output on every cycle, so any of these errors is reported within one cycle of reaching the ports.

// File: rtl/pdq_pkg.sv
package pdq_pkg;
  localparam int OPW = 8;
  localparam int EPW = 6;
  localparam int RGW = 3;

  localparam logic [OPW-1:0] OP_SEG_REG = 8'h8E;
  localparam logic [OPW-1:0] OP_SEG_MEM = 8'h8F;
  localparam logic [OPW-1:0] OP_FAR_JMP = 8'hEA;
  localparam logic [OPW-1:0] OP_FAR_CAL = 8'h9A;
  localparam logic [OPW-1:0] OP_HALT    = 8'hF4;
  localparam logic [OPW-1:0] OP_NEAR_JP = 8'hEB;
  localparam logic [OPW-1:0] OP_ARPL    = 8'h63;
  localparam logic [OPW-1:0] OP_STR     = 8'h0F;

  localparam logic [EPW-1:0] EP_GENERIC  = 6'h00;
  localparam logic [EPW-1:0] EP_SEGREG_R = 6'h01;
  localparam logic [EPW-1:0] EP_SEGMEM   = 6'h02;
  localparam logic [EPW-1:0] EP_FARJMP   = 6'h03;
  localparam logic [EPW-1:0] EP_FARCALL  = 6'h04;
  localparam logic [EPW-1:0] EP_HALT_R   = 6'h05;
  localparam logic [EPW-1:0] EP_NEARJMP  = 6'h06;
  localparam logic [EPW-1:0] EP_SEGREG_P = 6'h11;
  localparam logic [EPW-1:0] EP_HALT_P   = 6'h15;
  localparam logic [EPW-1:0] EP_ARPL_P   = 6'h16;
  localparam logic [EPW-1:0] EP_STR_P    = 6'h17;
  localparam logic [EPW-1:0] EP_INVALID  = 6'h3F;

  typedef struct packed {
    logic [OPW-1:0] opcode;
    logic [RGW-1:0] regf;
    logic [EPW-1:0] ep;
    logic           pe;
  } qent_t;

  function automatic logic [EPW-1:0] map_entry(input logic [OPW-1:0] op, input logic pe);
    logic [EPW-1:0] r;
    case (op)
      OP_SEG_REG: r = pe ? EP_SEGREG_P : EP_SEGREG_R;
      OP_SEG_MEM: r = EP_SEGMEM;
      OP_FAR_JMP: r = EP_FARJMP;
      OP_FAR_CAL: r = EP_FARCALL;
      OP_HALT:    r = pe ? EP_HALT_P : EP_HALT_R;
      OP_NEAR_JP: r = EP_NEARJMP;
      OP_ARPL:    r = pe ? EP_ARPL_P : EP_INVALID;
      OP_STR:     r = pe ? EP_STR_P : EP_INVALID;
      default:    r = EP_GENERIC;
    endcase
    return r;
  endfunction

  function automatic logic [19:0] real_base(input logic [15:0] sel);
    return {sel, 4'h0};
  endfunction

  function automatic logic is_shared(input logic [EPW-1:0] ep);
    return (ep == EP_SEGMEM) || (ep == EP_FARJMP) || (ep == EP_FARCALL);
  endfunction
endpackage

// File: rtl/pdq_decoder.sv
module pdq_decoder
  import pdq_pkg::*;
(
  input  logic [OPW-1:0] opcode_i,
  input  logic [RGW-1:0] reg_i,
  input  logic           pe_i,
  output qent_t          ent_o
);
  always_comb begin
    ent_o.opcode = opcode_i;
    ent_o.regf   = reg_i;
    ent_o.ep     = map_entry(opcode_i, pe_i);
    ent_o.pe     = pe_i;
  end
endmodule

// File: rtl/pdq_fifo.sv
module pdq_fifo
  import pdq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  clr_i,
  input  logic  push_i,
  input  qent_t din_i,
  input  logic  pop_i,
  output qent_t head_o,
  output logic  empty_o,
  output logic  full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  qent_t          mem [DEPTH];
  logic [PW-1:0]  wr_q, rd_q;
  logic [CW-1:0]  cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push_i && !clr_i && !rst && wr_q == PW'(g)) mem[g] <= din_i;
      end
    end
  endgenerate
endmodule

// File: rtl/pdq_segexec.sv
module pdq_segexec
  import pdq_pkg::*;
(
  input  logic           take_i,
  input  qent_t          head_i,
  input  logic           pe_live_i,
  input  logic [15:0]    gpr_i,
  output logic           seg_we_o,
  output logic [RGW-1:0] seg_idx_o,
  output logic [15:0]    seg_sel_o,
  output logic           base_we_o,
  output logic [19:0]    base_o,
  output logic           desc_req_o
);
  logic is_real_ld, is_prot_ld;
  assign is_real_ld = take_i && (head_i.ep == EP_SEGREG_R);
  assign is_prot_ld = take_i && (head_i.ep == EP_SEGREG_P);

  assign seg_we_o   = is_real_ld || is_prot_ld;
  assign seg_idx_o  = head_i.regf;
  assign seg_sel_o  = gpr_i;
  assign base_we_o  = is_real_ld;
  assign base_o     = real_base(gpr_i);
  assign desc_req_o = is_prot_ld || (take_i && pe_live_i && is_shared(head_i.ep));
endmodule

// File: rtl/predecode_ep_queue.sv
module predecode_ep_queue
  import pdq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pe_i,
  input  logic        dec_valid_i,
  input  logic [7:0]  dec_opcode_i,
  input  logic [2:0]  dec_reg_i,
  output logic        dec_ready_o,
  input  logic        flush_i,
  input  logic        ex_ready_i,
  input  logic [15:0] ex_gpr_i,
  output logic        ex_valid_o,
  output logic [5:0]  ex_ep_o,
  output logic [7:0]  ex_opcode_o,
  output logic [2:0]  ex_reg_o,
  output logic        ex_pe_dec_o,
  output logic        seg_we_o,
  output logic [2:0]  seg_idx_o,
  output logic [15:0] seg_sel_o,
  output logic        seg_base_we_o,
  output logic [19:0] seg_base_o,
  output logic        desc_req_o
);
  qent_t dec_ent_w, head_w;
  logic  empty_w, full_w;
  logic  fire_w, inv_take_w, flush_all_w, enq_w;
  logic [EPW-1:0] dec_ep_w;

  pdq_decoder u_dec (
    .opcode_i (dec_opcode_i),
    .reg_i    (dec_reg_i),
    .pe_i     (pe_i),
    .ent_o    (dec_ent_w)
  );
  assign dec_ep_w = dec_ent_w.ep;

  assign fire_w      = !empty_w && ex_ready_i;
  assign inv_take_w  = fire_w && (head_w.ep == EP_INVALID);
  assign flush_all_w = flush_i || inv_take_w;
  assign enq_w       = dec_valid_i && !full_w && !flush_all_w;

  pdq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (flush_all_w),
    .push_i  (enq_w),
    .din_i   (dec_ent_w),
    .pop_i   (fire_w),
    .head_o  (head_w),
    .empty_o (empty_w),
    .full_o  (full_w)
  );

  assign dec_ready_o = !full_w;
  assign ex_valid_o  = !empty_w;
  assign ex_ep_o     = head_w.ep;
  assign ex_opcode_o = head_w.opcode;
  assign ex_reg_o    = head_w.regf;
  assign ex_pe_dec_o = head_w.pe;

  pdq_segexec u_seg (
    .take_i     (fire_w),
    .head_i     (head_w),
    .pe_live_i  (pe_i),
    .gpr_i      (ex_gpr_i),
    .seg_we_o   (seg_we_o),
    .seg_idx_o  (seg_idx_o),
    .seg_sel_o  (seg_sel_o),
    .base_we_o  (seg_base_we_o),
    .base_o     (seg_base_o),
    .desc_req_o (desc_req_o)
  );
endmodule

// File: rtl/pdq_checker.sv
module pdq_checker
  import pdq_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        pe_i,
  input logic        flush_i,
  input logic        ex_ready_i,
  input logic        dec_ready_o,
  input logic        ex_valid_o,
  input logic [5:0]  ex_ep_o,
  input logic        seg_we_o,
  input logic        seg_base_we_o,
  input logic [19:0] seg_base_o,
  input logic [15:0] seg_sel_o,
  input logic        desc_req_o,
  input logic        enq_w,
  input logic [7:0]  dec_opcode_i,
  input logic [5:0]  dec_ep_w
);
  p_reset_empty_r1: assert property (@(posedge clk) rst |=> !ex_valid_o && dec_ready_o);

  p_real_illegal_r3: assert property (@(posedge clk) disable iff (rst)
    (enq_w && !pe_i && (dec_opcode_i == OP_ARPL || dec_opcode_i == OP_STR)) |-> dec_ep_w == EP_INVALID);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    !dec_ready_o |-> (ex_valid_o && !enq_w));

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !ex_valid_o);

  p_invalid_flush_r8: assert property (@(posedge clk) disable iff (rst)
    (ex_valid_o && ex_ready_i && ex_ep_o == EP_INVALID) |=> !ex_valid_o);

  p_base_value_r9: assert property (@(posedge clk) disable iff (rst)
    seg_base_we_o |-> (seg_we_o && seg_base_o == {seg_sel_o, 4'h0}));

  p_prot_no_base_r10: assert property (@(posedge clk) disable iff (rst)
    (ex_valid_o && ex_ready_i && ex_ep_o == EP_SEGREG_P) |-> (seg_we_o && desc_req_o && !seg_base_we_o));

  p_shared_live_pe_r11: assert property (@(posedge clk) disable iff (rst)
    (desc_req_o && !pe_i) |-> ex_ep_o == EP_SEGREG_P);
endmodule

bind predecode_ep_queue pdq_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .pe_i          (pe_i),
  .flush_i       (flush_i),
  .ex_ready_i    (ex_ready_i),
  .dec_ready_o   (dec_ready_o),
  .ex_valid_o    (ex_valid_o),
  .ex_ep_o       (ex_ep_o),
  .seg_we_o      (seg_we_o),
  .seg_base_we_o (seg_base_we_o),
  .seg_base_o    (seg_base_o),
  .seg_sel_o     (seg_sel_o),
  .desc_req_o    (desc_req_o),
  .enq_w         (enq_w),
  .dec_opcode_i  (dec_opcode_i),
  .dec_ep_w      (dec_ep_w)
);

// File: tb/predecode_ep_queue_tb_top.sv
module predecode_ep_queue_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic pe_i, dec_valid_i, flush_i, ex_ready_i;
  logic [7:0]  dec_opcode_i;
  logic [2:0]  dec_reg_i;
  logic [15:0] ex_gpr_i;
  logic dec_ready_o, ex_valid_o, ex_pe_dec_o, seg_we_o, seg_base_we_o, desc_req_o;
  logic [5:0]  ex_ep_o;
  logic [7:0]  ex_opcode_o;
  logic [2:0]  ex_reg_o, seg_idx_o;
  logic [15:0] seg_sel_o;
  logic [19:0] seg_base_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  predecode_ep_queue dut_i (.*);

  typedef struct {
    int op;
    int rg;
    int ep;
    int pe;
  } ment_t;
  ment_t mq[$];

  function automatic int ref_ep(int op, int pe);
    if (op == 'h8E) return pe ? 'h11 : 'h01;
    if (op == 'hF4) return pe ? 'h15 : 'h05;
    if (op == 'h63) return pe ? 'h16 : 'h3F;
    if (op == 'h0F) return pe ? 'h17 : 'h3F;
    if (op == 'h8F) return 'h02;
    if (op == 'hEA) return 'h03;
    if (op == 'h9A) return 'h04;
    if (op == 'hEB) return 'h06;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit v;
    bit take;
    int ep;
    v = (mq.size() != 0);
    ep = v ? mq[0].ep : 0;
    take = v && ex_ready_i;
    chk("R5", "dec_ready", dec_ready_o, mq.size() < 4);
    chk("R6", "ex_valid", ex_valid_o, v);
    if (v) begin
      chk("R2", "ex_ep", ex_ep_o, ep);
      chk("R6", "ex_opcode", ex_opcode_o, mq[0].op);
      chk("R6", "ex_reg", ex_reg_o, mq[0].rg);
      chk("R4", "ex_pe_dec", ex_pe_dec_o, mq[0].pe);
    end
    chk("R9", "seg_we", seg_we_o, take && (ep == 'h01 || ep == 'h11));
    chk("R9", "seg_base_we", seg_base_we_o, take && ep == 'h01);
    chk("R11", "desc_req", desc_req_o,
        take && (ep == 'h11 || (pe_i && (ep == 2 || ep == 3 || ep == 4))));
    if (take && ep == 'h01) begin
      chk("R9", "seg_idx", seg_idx_o, mq[0].rg);
      chk("R9", "seg_sel", seg_sel_o, ex_gpr_i);
      chk("R9", "seg_base", seg_base_o, ex_gpr_i * 16);
    end
  endtask

  task automatic model_edge();
    bit take, inv;
    int sz;
    sz = mq.size();
    take = (sz != 0) && ex_ready_i;
    inv = take && mq[0].ep == 'h3F;
    if (flush_i || inv) mq.delete();
    else begin
      if (take) void'(mq.pop_front());
      if (dec_valid_i && sz < 4) begin
        ment_t e;
        e.op = dec_opcode_i; e.rg = dec_reg_i; e.pe = pe_i;
        e.ep = ref_ep(dec_opcode_i, pe_i);
        mq.push_back(e);
      end
    end
  endtask

  task automatic step(bit pe, bit dv, int op, int rg, bit fl, bit rdy, int gpr);
    pe_i = pe; dec_valid_i = dv; dec_opcode_i = 8'(op); dec_reg_i = 3'(rg);
    flush_i = fl; ex_ready_i = rdy; ex_gpr_i = 16'(gpr);
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    pe_i = 0; dec_valid_i = 0; dec_opcode_i = 0; dec_reg_i = 0;
    flush_i = 0; ex_ready_i = 0; ex_gpr_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset ex_valid", ex_valid_o, 0);
    chk("R1", "reset dec_ready", dec_ready_o, 1);
    rst = 1'b0;
    #1;
    chk("R1", "post-reset ex_valid", ex_valid_o, 0);

    // R5: fill in real mode, then offer a fifth opcode while full
    step(0, 1, 'h8E, 3, 0, 0, 0);
    step(0, 1, 'hF4, 0, 0, 0, 0);
    step(0, 1, 'h90, 1, 0, 0, 0);
    step(0, 1, 'h8E, 2, 0, 0, 0);
    step(0, 1, 'hEA, 0, 0, 0, 0);
    chk("R5", "full blocks", dec_ready_o, 0);
    // R4: set PE, drain; entries keep real-mode codes
    step(1, 0, 0, 0, 0, 1, 'h1234);
    step(1, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 1, 0);
    chk("R4", "kept real code", ex_ep_o, 'h01);
    step(1, 0, 0, 0, 0, 1, 'hF00D);
    chk("R6", "drained", ex_valid_o, 0);

    // R7: flush with a simultaneous enqueue
    step(1, 1, 'h8E, 1, 0, 0, 0);
    step(1, 1, 'h63, 0, 0, 0, 0);
    step(1, 1, 'h0F, 0, 1, 0, 0);
    chk("R7", "flush empties", ex_valid_o, 0);

    // R2/R10: protected-mode variants
    step(1, 1, 'h8E, 5, 0, 0, 0);
    step(1, 1, 'h63, 0, 0, 0, 0);
    step(1, 1, 'h0F, 0, 0, 0, 0);
    step(1, 1, 'hF4, 0, 0, 0, 0);
    chk("R10", "prot seg code", ex_ep_o, 'h11);
    step(1, 0, 0, 0, 0, 1, 'h0010);
    repeat (3) step(1, 0, 0, 0, 0, 1, 0);

    // R3/R8: illegal-in-real-mode becomes invalid and flushes
    step(0, 1, 'h90, 0, 0, 0, 0);
    step(0, 1, 'h63, 0, 0, 0, 0);
    step(0, 1, 'h0F, 0, 0, 1, 0);
    chk("R3", "invalid code", ex_ep_o, 'h3F);
    step(0, 1, 'h90, 0, 0, 1, 0);
    chk("R8", "invalid flushes", ex_valid_o, 0);

    // R11: shared entries with the live PE toggled at execute
    step(0, 1, 'h8F, 0, 0, 0, 0);
    step(0, 1, 'hEA, 0, 0, 0, 0);
    step(0, 1, 'h9A, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 1, 0);

    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      int ops[10] = '{'h8E, 'h8F, 'hEA, 'h9A, 'hF4, 'hEB, 'h63, 'h0F, 'h90, 'h01};
      step(1'($urandom % 4 != 0 ? (i / 64) % 2 : $urandom % 2),
           1'($urandom % 3 != 0), ops[$urandom % 10], int'($urandom % 8),
           1'($urandom % 23 == 0), 1'($urandom % 2), int'($urandom % 65536));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule